// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit general registers of a processor core that runs in several privilege modes, together with the current status word and one saved status word per exception bank. A 5-bit mode value selects a bank. Depending on the bank, some registers are swapped for private copies. The fast-interrupt bank has its own r8 to r14. The other exception banks and the system bank each have their own r13 and r14. Encodings that name no real mode select an empty bank, whose banked registers read as zero.

The core reads through two ports and writes through one. All three always act on the live view of the current mode. A separate port can reach any register as it is seen from another mode, without changing mode. A mode change comes either from an explicit request or from a write to the control byte of the current status word. The change completes in one clock. The bank held in the state register is the block's state, and the mode change is its only transition. Either source of a mode change moves the state to the bank of the new mode. When the new bank is the same as the old one, the state is unchanged. The states are user, fast-interrupt, interrupt, supervisor, abort, undefined, system and empty. The program counter, r15, is kept like any other unbanked register.

Top module: `banked_regfile`

## Requirements
- R1: After reset the mode is 0x13 (supervisor). Every general register and every stored copy reads zero. The current status word reads 0x00000013 and each saved status word reads zero.
- R2: Modes 0x10 and 0x00 select user, 0x11 and 0x01 select fast-interrupt, 0x12 and 0x02 select interrupt, and 0x13 and 0x03 select supervisor. 0x17 selects abort, 0x1B selects undefined and 0x1F selects system. Every other code selects the empty bank.
- R3: A request taken at a clock edge shows its mode on `cur_mode` from that edge on. Reads made after that edge see the new bank's registers.
- R4: Changing between user, interrupt, supervisor, abort, undefined and system swaps only r13 and r14. The registers r0 to r12 and r15 are shared among these banks.
- R5: The fast-interrupt bank has private r8 to r14. When this bank is left, the r8 to r12 values that the other banks held before entry are restored.
- R6: On entry to the empty bank, r8 to r14 read zero. Whatever is written to them there is lost on exit. On exit, the other banks' r8 to r14 are as they were before entry.
- R7: A mode change between two codes that select the same bank leaves every register unchanged.
- R8: The other-mode port reaches the registers of the bank selected by `xm_mode`: that bank's private copy if it is not current, the live register if it is current. Registers that no bank makes private are shared by all banks. For a mode that selects the empty bank, r8 to r14 read zero and writes to them are dropped.
- R9: An other-mode write is dropped in a cycle that swaps banks. If it targets the same live register as a write from the main port, the main port's data is kept.
- R10: A main-port write in the same cycle as a bank swap lands in the bank being left.
- R11: In a status write, mask bit 0 enables bits 7:0, bit 1 enables bits 15:8, bit 2 enables bits 23:16 and bit 3 enables bits 31:24. A write to the current word with bit 0 set changes the mode to data bits 4:0. An explicit mode request in the same cycle takes priority for the mode.
- R12: In the user bank, only bits 31:24 of the current status word can be written. The mode cannot change this way. The system bank has no such limit.
- R13: The fast-interrupt, interrupt, supervisor, abort and undefined banks each hold one saved status word. Selecting the saved word (`st_saved`=1) in the user, system or empty bank reads the current word. A saved-word write in those banks is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | Mode change request |
| sw_mode | input | 5 | Requested mode |
| cur_mode | output | 5 | Current mode |
| ra_idx | input | 4 | Read port A register number |
| ra_data | output | DW | Read port A data (live view) |
| rb_idx | input | 4 | Read port B register number |
| rb_data | output | DW | Read port B data (live view) |
| wr_en | input | 1 | Main write enable |
| wr_idx | input | 4 | Main write register number |
| wr_data | input | DW | Main write data |
| xm_mode | input | 5 | Mode through which the other-mode port looks |
| xm_idx | input | 4 | Other-mode register number |
| xm_we | input | 1 | Other-mode write enable |
| xm_wdata | input | DW | Other-mode write data |
| xm_rdata | output | DW | Other-mode read data |
| st_saved | input | 1 | 1 selects the current bank's saved status word, 0 the current one |
| st_mask | input | DW/8 | Byte field enables for a status write |
| st_we | input | 1 | Status write enable |
| st_wdata | input | DW | Status write data |
| st_rdata | output | DW | Selected status word |

## Verification
The bound checker watches the mode sequencing on every cycle. It checks that a request's mode appears one edge later and that the mode holds when nothing asks it to change. It checks that the user bank can never change the mode through its status word. It checks that the empty bank reads zero right after entry, and that a change between two codes of the same bank leaves a register read unchanged. The contents of the private copies need the bench's scenarios. These cover values written in one bank and read back after a visit to others, the other-mode port's path to each kind of copy, the collision of writes with a swap, and the masked and dropped status writes.

// File: rtl/rfbank_pkg.sv
package rfbank_pkg;

    typedef enum logic [2:0] {
        BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_SYS, BK_DUM
    } bank_e;

    // Where an other-mode access lands
    typedef enum logic [2:0] {
        XT_LIVE, XT_USRHI, XT_FIQ, XT_SP, XT_LR, XT_ZERO
    } xtgt_e;

    localparam logic [4:0] RESET_MODE = 5'h13;

    function automatic bank_e bank_of(input logic [4:0] m);
        bank_e b;
        case (m)
            5'h00, 5'h10: b = BK_USR;
            5'h01, 5'h11: b = BK_FIQ;
            5'h02, 5'h12: b = BK_IRQ;
            5'h03, 5'h13: b = BK_SVC;
            5'h17:        b = BK_ABT;
            5'h1B:        b = BK_UND;
            5'h1F:        b = BK_SYS;
            default:      b = BK_DUM;
        endcase
        return b;
    endfunction

    // Banks that privately hold only r13/r14
    function automatic logic is_plain(input bank_e b);
        return (b != BK_FIQ) && (b != BK_DUM);
    endfunction

    function automatic logic [2:0] plain_slot(input bank_e b);
        logic [2:0] s;
        case (b)
            BK_IRQ:  s = 3'd1;
            BK_SVC:  s = 3'd2;
            BK_ABT:  s = 3'd3;
            BK_UND:  s = 3'd4;
            BK_SYS:  s = 3'd5;
            default: s = 3'd0;
        endcase
        return s;
    endfunction

    function automatic logic [2:0] saved_slot(input bank_e b);
        logic [2:0] s;
        case (b)
            BK_IRQ:  s = 3'd1;
            BK_SVC:  s = 3'd2;
            BK_ABT:  s = 3'd3;
            BK_UND:  s = 3'd4;
            default: s = 3'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rf_gpr_bank.sv
module rf_gpr_bank
    import rfbank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bank_e         cur_bank,
    input  bank_e         nxt_bank,
    input  logic [3:0]    ra_idx,
    output logic [DW-1:0] ra_data,
    input  logic [3:0]    rb_idx,
    output logic [DW-1:0] rb_data,
    input  logic          wr_en,
    input  logic [3:0]    wr_idx,
    input  logic [DW-1:0] wr_data,
    input  bank_e         xm_bank,
    input  logic [3:0]    xm_idx,
    input  logic          xm_we,
    input  logic [DW-1:0] xm_wdata,
    output logic [DW-1:0] xm_rdata
);
    localparam int NREG   = 16;
    localparam int LO     = 8;
    localparam int NHI    = 7;
    localparam int NSHARE = 5;
    localparam int NPLAIN = 6;
    localparam int SP     = 13;
    localparam int LR     = 14;

    logic [DW-1:0] live   [NREG];
    logic [DW-1:0] pre    [NREG];
    logic [DW-1:0] usr_hi [NSHARE];
    logic [DW-1:0] fiq_hi [NHI];
    logic [DW-1:0] pl_sp  [NPLAIN];
    logic [DW-1:0] pl_lr  [NPLAIN];

    logic  swap;
    xtgt_e xt;

    assign swap    = (nxt_bank != cur_bank);
    assign ra_data = live[ra_idx];
    assign rb_data = live[rb_idx];

    // Resolve the other-mode target
    always_comb begin
        xt = XT_LIVE;
        if (xm_idx >= 4'd8 && xm_idx <= 4'd14) begin
            unique case (xm_bank)
                BK_DUM: xt = (cur_bank == BK_DUM) ? XT_LIVE : XT_ZERO;
                BK_FIQ: xt = (cur_bank == BK_FIQ) ? XT_LIVE : XT_FIQ;
                default: begin
                    if (xm_idx <= 4'd12)
                        xt = is_plain(cur_bank) ? XT_LIVE : XT_USRHI;
                    else if (xm_bank == cur_bank)
                        xt = XT_LIVE;
                    else
                        xt = (xm_idx == 4'd13) ? XT_SP : XT_LR;
                end
            endcase
        end
    end

    always_comb begin
        unique case (xt)
            XT_LIVE:  xm_rdata = live[xm_idx];
            XT_USRHI: xm_rdata = usr_hi[xm_idx[2:0]];
            XT_FIQ:   xm_rdata = fiq_hi[xm_idx[2:0]];
            XT_SP:    xm_rdata = pl_sp[plain_slot(xm_bank)];
            XT_LR:    xm_rdata = pl_lr[plain_slot(xm_bank)];
            default:  xm_rdata = '0;
        endcase
    end

    // Live file after this cycle's writes; main port written last wins
    always_comb begin
        for (int i = 0; i < NREG; i++) pre[i] = live[i];
        if (xm_we && !swap && xt == XT_LIVE) pre[xm_idx] = xm_wdata;
        if (wr_en) pre[wr_idx] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)   live[i]   <= '0;
            for (int i = 0; i < NSHARE; i++) usr_hi[i] <= '0;
            for (int i = 0; i < NHI; i++)    fiq_hi[i] <= '0;
            for (int i = 0; i < NPLAIN; i++) begin
                pl_sp[i] <= '0;
                pl_lr[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) live[i] <= pre[i];
            if (!swap && xm_we) begin
                unique case (xt)
                    XT_USRHI: usr_hi[xm_idx[2:0]]      <= xm_wdata;
                    XT_FIQ:   fiq_hi[xm_idx[2:0]]      <= xm_wdata;
                    XT_SP:    pl_sp[plain_slot(xm_bank)] <= xm_wdata;
                    XT_LR:    pl_lr[plain_slot(xm_bank)] <= xm_wdata;
                    default: ;
                endcase
            end
            if (swap) begin
                // save side
                if (is_plain(cur_bank)) begin
                    pl_sp[plain_slot(cur_bank)] <= pre[SP];
                    pl_lr[plain_slot(cur_bank)] <= pre[LR];
                    if (!is_plain(nxt_bank))
                        for (int k = 0; k < NSHARE; k++) usr_hi[k] <= pre[LO+k];
                end else if (cur_bank == BK_FIQ) begin
                    for (int k = 0; k < NHI; k++) fiq_hi[k] <= pre[LO+k];
                end
                // restore side
                if (is_plain(nxt_bank)) begin
                    live[SP] <= pl_sp[plain_slot(nxt_bank)];
                    live[LR] <= pl_lr[plain_slot(nxt_bank)];
                    if (!is_plain(cur_bank))
                        for (int k = 0; k < NSHARE; k++) live[LO+k] <= usr_hi[k];
                end else if (nxt_bank == BK_FIQ) begin
                    for (int k = 0; k < NHI; k++) live[LO+k] <= fiq_hi[k];
                end else begin
                    for (int k = 0; k < NHI; k++) live[LO+k] <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/rf_status.sv
module rf_status
    import rfbank_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NSAVED = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      mode_q,
    input  logic            lock_ctl,
    input  logic            has_saved,
    input  logic [2:0]      sv_slot,
    input  logic            st_saved,
    input  logic [DW/8-1:0] st_mask,
    input  logic            st_we,
    input  logic [DW-1:0]   st_wdata,
    output logic [DW-1:0]   st_rdata,
    output logic            ctl_wr,
    output logic [4:0]      ctl_mode
);
    localparam int NFLD = DW / 8;
    localparam logic [NFLD-1:0] FLAG_ONLY = {1'b1, {(NFLD-1){1'b0}}};

    logic [DW-6:0]   cur_hi;
    logic [DW-1:0]   saved_q [NSAVED];
    logic [DW-1:0]   cur_full;
    logic [DW-1:0]   cur_merged;
    logic [NFLD-1:0] eff_mask;

    function automatic logic [DW-1:0] merge_fields(input logic [DW-1:0] old_v,
                                                   input logic [DW-1:0] new_v,
                                                   input logic [NFLD-1:0] m);
        logic [DW-1:0] r;
        r = old_v;
        for (int f = 0; f < NFLD; f++)
            if (m[f]) r[f*8 +: 8] = new_v[f*8 +: 8];
        return r;
    endfunction

    assign cur_full   = {cur_hi, mode_q};
    assign eff_mask   = lock_ctl ? (st_mask & FLAG_ONLY) : st_mask;
    assign cur_merged = merge_fields(cur_full, st_wdata, eff_mask);
    assign ctl_wr     = st_we && !st_saved && eff_mask[0];
    assign ctl_mode   = cur_merged[4:0];
    assign st_rdata   = (st_saved && has_saved) ? saved_q[sv_slot] : cur_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_hi <= '0;
            for (int i = 0; i < NSAVED; i++) saved_q[i] <= '0;
        end else if (st_we) begin
            if (!st_saved)
                cur_hi <= cur_merged[DW-1:5];
            else if (has_saved)
                saved_q[sv_slot] <= merge_fields(saved_q[sv_slot], st_wdata, st_mask);
        end
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rfbank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_req,
    input  logic [4:0]      sw_mode,
    output logic [4:0]      cur_mode,
    input  logic [3:0]      ra_idx,
    output logic [DW-1:0]   ra_data,
    input  logic [3:0]      rb_idx,
    output logic [DW-1:0]   rb_data,
    input  logic            wr_en,
    input  logic [3:0]      wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic [4:0]      xm_mode,
    input  logic [3:0]      xm_idx,
    input  logic            xm_we,
    input  logic [DW-1:0]   xm_wdata,
    output logic [DW-1:0]   xm_rdata,
    input  logic            st_saved,
    input  logic [DW/8-1:0] st_mask,
    input  logic            st_we,
    input  logic [DW-1:0]   st_wdata,
    output logic [DW-1:0]   st_rdata
);
    localparam int NSAVED = 5;

    bank_e      bank_q, bank_nx;
    logic [4:0] mode_q, mode_nx;
    logic       ctl_wr;
    logic [4:0] ctl_mode;
    logic       lock_ctl, has_saved;

    // next-state: request first, then control-field write
    always_comb begin
        if (sw_req)      mode_nx = sw_mode;
        else if (ctl_wr) mode_nx = ctl_mode;
        else             mode_nx = mode_q;
        bank_nx = bank_of(mode_nx);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RESET_MODE;
            bank_q <= BK_SVC;
        end else begin
            mode_q <= mode_nx;
            bank_q <= bank_nx;
        end
    end

    // outputs per state
    always_comb begin
        unique case (bank_q)
            BK_USR: begin lock_ctl = 1'b1; has_saved = 1'b0; end
            BK_SYS: begin lock_ctl = 1'b0; has_saved = 1'b0; end
            BK_DUM: begin lock_ctl = 1'b0; has_saved = 1'b0; end
            BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND:
                    begin lock_ctl = 1'b0; has_saved = 1'b1; end
            default: begin lock_ctl = 1'b0; has_saved = 1'b0; end
        endcase
    end

    assign cur_mode = mode_q;

    rf_gpr_bank #(.DW(DW)) u_gpr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_bank (bank_q),
        .nxt_bank (bank_nx),
        .ra_idx   (ra_idx),
        .ra_data  (ra_data),
        .rb_idx   (rb_idx),
        .rb_data  (rb_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .xm_bank  (bank_of(xm_mode)),
        .xm_idx   (xm_idx),
        .xm_we    (xm_we),
        .xm_wdata (xm_wdata),
        .xm_rdata (xm_rdata)
    );

    rf_status #(.DW(DW), .NSAVED(NSAVED)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_q    (mode_q),
        .lock_ctl  (lock_ctl),
        .has_saved (has_saved),
        .sv_slot   (saved_slot(bank_q)),
        .st_saved  (st_saved),
        .st_mask   (st_mask),
        .st_we     (st_we),
        .st_wdata  (st_wdata),
        .st_rdata  (st_rdata),
        .ctl_wr    (ctl_wr),
        .ctl_mode  (ctl_mode)
    );

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
    import rfbank_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sw_req,
    input logic [4:0]    sw_mode,
    input logic [4:0]    cur_mode,
    input logic [3:0]    ra_idx,
    input logic [DW-1:0] ra_data,
    input logic          wr_en,
    input logic          xm_we,
    input logic          st_we
);
    // R3
    req_mode_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |=> (cur_mode == $past(sw_mode)));

    // R11
    mode_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_req && !st_we) |=> $stable(cur_mode));

    // R12
    user_no_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_req && bank_of(cur_mode) == BK_USR) |=> $stable(cur_mode));

    // R6
    empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && bank_of(sw_mode) == BK_DUM && bank_of(cur_mode) != BK_DUM)
        |=> ((ra_idx < 4'd8) || (ra_idx == 4'd15) || (ra_data == '0)));

    // R7
    same_bank_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && bank_of(sw_mode) == bank_of(cur_mode) && !wr_en && !xm_we)
        |=> ((ra_idx != $past(ra_idx)) || (ra_data == $past(ra_data))));
endmodule

bind banked_regfile banked_regfile_chk u_chk (.*);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sw_req;
    logic [4:0]    sw_mode;
    logic [4:0]    cur_mode;
    logic [3:0]    ra_idx, rb_idx, wr_idx, xm_idx;
    logic [DW-1:0] ra_data, rb_data, wr_data, xm_wdata, xm_rdata, st_wdata, st_rdata;
    logic          wr_en, xm_we, st_saved, st_we;
    logic [4:0]    xm_mode;
    logic [3:0]    st_mask;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    banked_regfile #(.DW(DW)) u0 (.*);

    task automatic idle();
        sw_req = 0; sw_mode = '0; wr_en = 0; wr_idx = '0; wr_data = '0;
        xm_we = 0; xm_wdata = '0; xm_mode = '0; xm_idx = '0;
        st_saved = 0; st_mask = '0; st_we = 0; st_wdata = '0;
        ra_idx = '0; rb_idx = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [3:0] i, input logic [31:0] exp);
        ra_idx = i; rb_idx = i; #1;
        chk({tag, " portA"}, ra_data, exp);
        chk({tag, " portB"}, rb_data, exp);
    endtask

    task automatic chk_xm(input string tag, input logic [4:0] m, input logic [3:0] i,
                          input logic [31:0] exp);
        xm_mode = m; xm_idx = i; #1;
        chk(tag, xm_rdata, exp);
    endtask

    task automatic chk_st(input string tag, input logic sv, input logic [31:0] exp);
        st_saved = sv; st_we = 0; #1;
        chk(tag, st_rdata, exp);
        st_saved = 0;
    endtask

    task automatic wreg(input logic [3:0] i, input logic [31:0] v);
        wr_en = 1; wr_idx = i; wr_data = v; tick(); idle();
    endtask

    task automatic swm(input logic [4:0] m);
        sw_req = 1; sw_mode = m; tick(); idle();
    endtask

    task automatic wst(input logic sv, input logic [3:0] mk, input logic [31:0] v);
        st_we = 1; st_saved = sv; st_mask = mk; st_wdata = v; tick(); idle();
    endtask

    task automatic t_reset();
        chk("R1 mode", {27'd0, cur_mode}, 32'h13);
        chk_reg("R1 r0", 4'd0, 0);
        chk_reg("R1 r13", 4'd13, 0);
        chk_st("R1 current status", 0, 32'h13);
        chk_st("R1 saved status", 1, 0);
    endtask

    task automatic t_shared();
        wreg(4'd3, 32'h11110003);
        chk_reg("R4 r3 write", 4'd3, 32'h11110003);
        wreg(4'd13, 32'hA13); wreg(4'd14, 32'hA14); wreg(4'd8, 32'hC8);
        swm(5'h12);
        chk("R3 mode irq", {27'd0, cur_mode}, 32'h12);
        chk_reg("R3 irq r13 private", 4'd13, 0);
        chk_reg("R4 r8 shared", 4'd8, 32'hC8);
        chk_reg("R4 r3 shared", 4'd3, 32'h11110003);
        wreg(4'd13, 32'hB13);
        swm(5'h13);
        chk_reg("R4 svc r13 back", 4'd13, 32'hA13);
        chk_reg("R4 svc r14 back", 4'd14, 32'hA14);
    endtask

    task automatic t_fast();
        wreg(4'd12, 32'hD12);
        swm(5'h11);
        chk_reg("R5 fiq r8", 4'd8, 0);
        chk_reg("R5 fiq r12", 4'd12, 0);
        chk_reg("R5 fiq r13", 4'd13, 0);
        wreg(4'd8, 32'hE8);
        swm(5'h10);
        chk_reg("R5 usr r8 restored", 4'd8, 32'hC8);
        chk_reg("R5 usr r12 restored", 4'd12, 32'hD12);
        chk_reg("R5 usr r13", 4'd13, 0);
        swm(5'h11);
        chk_reg("R5 fiq r8 kept", 4'd8, 32'hE8);
        swm(5'h13);
        chk_reg("R5 svc r8", 4'd8, 32'hC8);
        chk_reg("R5 svc r13", 4'd13, 32'hA13);
    endtask

    task automatic t_alias();
        swm(5'h03);
        chk("R2 alias mode", {27'd0, cur_mode}, 32'h03);
        chk_reg("R7 alias r13", 4'd13, 32'hA13);
        chk_reg("R7 alias r8", 4'd8, 32'hC8);
        swm(5'h01);
        chk_reg("R2 alias fiq r8", 4'd8, 32'hE8);
        swm(5'h13);
    endtask

    task automatic t_empty();
        swm(5'h05);
        chk_reg("R6 empty r8", 4'd8, 0);
        chk_reg("R6 empty r14", 4'd14, 0);
        chk_reg("R6 empty r3", 4'd3, 32'h11110003);
        wreg(4'd8, 32'hF8);
        swm(5'h13);
        chk_reg("R6 svc r8 after empty", 4'd8, 32'hC8);
        chk_reg("R6 svc r13 after empty", 4'd13, 32'hA13);
        swm(5'h1A);
        chk_reg("R2 R6 other empty code r8", 4'd8, 0);
        swm(5'h13);
    endtask

    task automatic t_other_mode();
        chk_xm("R8 irq r13", 5'h12, 4'd13, 32'hB13);
        chk_xm("R8 usr r8 live", 5'h10, 4'd8, 32'hC8);
        chk_xm("R8 fiq r8", 5'h11, 4'd8, 32'hE8);
        chk_xm("R8 own r13", 5'h13, 4'd13, 32'hA13);
        chk_xm("R8 unbanked r3", 5'h12, 4'd3, 32'h11110003);
        chk_xm("R8 empty r10", 5'h1A, 4'd10, 0);
        xm_we = 1; xm_mode = 5'h11; xm_idx = 4'd9; xm_wdata = 32'h99; tick(); idle();
        xm_we = 1; xm_mode = 5'h12; xm_idx = 4'd14; xm_wdata = 32'h1414; tick(); idle();
        chk_xm("R8 irq r14 written", 5'h12, 4'd14, 32'h1414);
        chk_reg("R8 svc r9 untouched", 4'd9, 0);
        chk_reg("R8 svc r14 untouched", 4'd14, 32'hA14);
        swm(5'h11);
        chk_reg("R8 fiq r9 written", 4'd9, 32'h99);
        swm(5'h13);
    endtask

    task automatic t_collide();
        wr_en = 1; wr_idx = 4'd13; wr_data = 32'h5513;
        sw_req = 1; sw_mode = 5'h12;
        xm_we = 1; xm_mode = 5'h17; xm_idx = 4'd13; xm_wdata = 32'h77;
        tick(); idle();
        chk_reg("R10 irq r13 not overwritten", 4'd13, 32'hB13);
        chk_xm("R9 abt r13 write dropped", 5'h17, 4'd13, 0);
        swm(5'h13);
        chk_reg("R10 svc r13 got write", 4'd13, 32'h5513);
        wr_en = 1; wr_idx = 4'd4; wr_data = 32'h44;
        xm_we = 1; xm_mode = 5'h12; xm_idx = 4'd4; xm_wdata = 32'h66;
        tick(); idle();
        chk_reg("R9 main port wins", 4'd4, 32'h44);
    endtask

    task automatic t_status();
        wst(0, 4'b1000, 32'hF0000000);
        chk_st("R11 flags field", 0, 32'hF0000013);
        wst(0, 4'b0100, 32'h00AB0000);
        chk_st("R11 status field", 0, 32'hF0AB0013);
        wst(1, 4'b1111, 32'h12345678);
        chk_st("R13 svc saved full", 1, 32'h12345678);
        wst(1, 4'b0010, 32'h0000CD00);
        chk_st("R11 saved ext field", 1, 32'h1234CD78);
        wst(0, 4'b0001, 32'h000000D2);
        chk("R11 ctl write mode", {27'd0, cur_mode}, 32'h12);
        chk_st("R11 ctl write value", 0, 32'hF0AB00D2);
        chk_st("R13 irq saved own", 1, 0);
        st_we = 1; st_saved = 0; st_mask = 4'b0001; st_wdata = 32'h000000F7;
        sw_req = 1; sw_mode = 5'h13;
        tick(); idle();
        chk("R11 request priority", {27'd0, cur_mode}, 32'h13);
        chk_st("R11 ctl bits with request", 0, 32'hF0AB00F3);
        chk_st("R13 svc saved kept", 1, 32'h1234CD78);
    endtask

    task automatic t_user();
        swm(5'h10);
        chk_st("R12 user current", 0, 32'hF0AB00F0);
        wst(0, 4'b1111, 32'h0F000011);
        chk("R12 user mode locked", {27'd0, cur_mode}, 32'h10);
        chk_st("R12 user flags only", 0, 32'h0FAB00F0);
        chk_st("R13 user saved reads current", 1, 32'h0FAB00F0);
        wst(1, 4'b1111, 32'hDEADBEEF);
        chk_st("R13 user saved write dropped", 0, 32'h0FAB00F0);
        swm(5'h1F);
        chk_st("R13 sys saved reads current", 1, 32'h0FAB00FF);
        wst(0, 4'b0001, 32'h000000F3);
        chk("R12 sys ctl allowed", {27'd0, cur_mode}, 32'h13);
        chk_st("R13 svc saved after user", 1, 32'h1234CD78);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R3 act=timeout exp=complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        t_reset();
        t_shared();
        t_fast();
        t_alias();
        t_empty();
        t_other_mode();
        t_collide();
        t_status();
        t_user();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule